// File: doc/BRIEF.md
# DMA Channel Run-Control and Status Registers

This block is the software-visible control and status register file of one descriptor-driven DMA channel. Software starts, pauses, flushes, wakes and resets the channel by writing a single control word. The upper halfword of that word selects which status bits change, and the lower halfword gives their new values. Any one bit can therefore change without a read-modify-write sequence. Reads at either the control or the status address return the composed status word.

The run, pause, flush and wake bits drive a command engine, which sits outside this block. The engine reports back its active level, a dead condition, a branch-taken flag and a completed flush. An 8-bit device status also enters the status word. The block also holds a 64-bit command pointer, which can be loaded only while the channel is stopped and is aligned to a 16-byte descriptor. It holds a transfer-mode word and three condition-select registers. Each select register raises a condition output (interrupt, branch, wait) when the masked low halfword of status equals a stored value.

Registers are 32-bit words addressed by a 3-bit word index. Bus bit i is register bit i, with byte 0 on lanes 7:0 (little-endian). Writes take effect at the next clock edge. Reads are combinational from the registered state.

Top module: `dma_chan_regs`

## Requirements
- R1: After reset, every register reads 0 and the run, pause, flush and wake outputs are 0.
- R2: A write to word 0 updates each of RUN (bit 15), PAUSE (bit 14), FLUSH (bit 13) and WAKE (bit 12) from data bit n only when data bit n+16 is 1. Every other control bit holds its value. The new value is visible from the next clock edge.
- R3: A write to word 0 with mask 0xFC00 and value 0 clears RUN, PAUSE, FLUSH, WAKE and DEAD. RUN then reads 0 and the run output is low.
- R4: Software cannot set ACTIVE (bit 10), DEAD (bit 11), branch-taken (bit 8), bit 9, the device bits 7:0 or bits 31:16. A masked write of 0 to DEAD or to branch-taken clears that bit.
- R5: DEAD and branch-taken are set by a one-cycle engine pulse and stay set until software clears them. When an engine set and a software clear fall in the same cycle, the set wins.
- R6: ACTIVE reads the engine active level one clock later. A masked software write of 0 to ACTIVE forces it to 0 for that update only.
- R7: A flush-done pulse clears FLUSH. A software write to FLUSH in the same cycle takes priority over the pulse.
- R8: Status bits 7:0 show the device status input one clock later. Words 0 and 1 read the same status word, and bits 31:16 of that word are 0.
- R9: The command pointer is held in word 2 (high half) and word 3 (low half). Writes to either word are dropped while RUN is 1. Bits 3:0 of word 3 always read 0.
- R10: Words 4, 5 and 6 hold a select mask in bits 31:16 and a value in bits 15:0. They drive the interrupt, branch and wait condition outputs respectively. Each output is 1 exactly when (status[15:0] AND mask) equals value.
- R11: Word 7 (transfer mode) and the select words read back the last written value, whatever the state of RUN.
- R12: The run, pause, flush and wake outputs always equal status bits 15, 14, 13 and 12.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Word index for reads and writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| eng_active | input | 1 | Engine busy level |
| eng_dead | input | 1 | Engine dead pulse |
| eng_bt | input | 1 | Engine branch-taken pulse |
| eng_flush_done | input | 1 | Flush drained pulse |
| dev_status | input | 8 | Device status bits |
| ctl_run | output | 1 | Run control to engine |
| ctl_pause | output | 1 | Pause control to engine |
| ctl_flush | output | 1 | Flush control to engine |
| ctl_wake | output | 1 | Wake control to engine |
| cmd_ptr | output | 64 | Command pointer {high, low} |
| xfer_mode | output | 32 | Transfer mode word |
| cond_intr | output | 1 | Interrupt condition |
| cond_br | output | 1 | Branch condition |
| cond_wait | output | 1 | Wait condition |

## Verification
Two collisions can occur in one cycle between the command engine and software. An engine pulse setting DEAD or branch-taken can arrive while software writes a masked clear of the same bit. A flush-done pulse can arrive while software writes FLUSH back to 1. The bench raises the engine input and the bus write at the same falling edge, so both are seen by the same rising edge. It then reads status one edge later and expects the engine set to have won in the first case and the software value in the second. Around these collisions it sweeps all 256 mask and value pairs over the four control bits and all 256 device status codes against three fixed select patterns.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;
    localparam int unsigned WORD_W = 32;
    localparam int unsigned HALF_W = 16;
    localparam int unsigned DEV_W  = 8;
    localparam int unsigned ADDR_W = 3;
    localparam int unsigned N_COND = 3;

    localparam int B_RUN    = 15;
    localparam int B_PAUSE  = 14;
    localparam int B_FLUSH  = 13;
    localparam int B_WAKE   = 12;
    localparam int B_DEAD   = 11;
    localparam int B_ACTIVE = 10;
    localparam int B_BT     = 8;

    typedef enum logic [ADDR_W-1:0] {
        A_CTRL     = 3'd0,
        A_STAT     = 3'd1,
        A_PTR_HI   = 3'd2,
        A_PTR_LO   = 3'd3,
        A_SEL_INT  = 3'd4,
        A_SEL_BR   = 3'd5,
        A_SEL_WAIT = 3'd6,
        A_XMODE    = 3'd7
    } reg_addr_e;

    typedef struct packed {
        logic run;
        logic pause;
        logic flush;
        logic wake;
        logic dead;
        logic active;
        logic bt;
    } chan_bits_t;
endpackage

// File: rtl/chan_status_reg.sv
module chan_status_reg
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ctl_we,
    input  logic [HALF_W-1:0] wmask,
    input  logic [HALF_W-1:0] wval,
    input  logic              eng_active,
    input  logic              eng_dead,
    input  logic              eng_bt,
    input  logic              eng_flush_done,
    input  logic [DEV_W-1:0]  dev_status,
    output chan_bits_t        bits,
    output logic [WORD_W-1:0] status_word
);
    typedef struct packed {
        chan_bits_t       b;
        logic [DEV_W-1:0] dev;
    } st_t;

    st_t st_d, st_q;

    logic [HALF_W-1:0] sel_d;
    logic [HALF_W-1:0] clr_d;

    always_comb begin
        sel_d = ctl_we ? wmask : '0;
        clr_d = sel_d & ~wval;
        st_d  = st_q;
        st_d.dev = dev_status;

        if (sel_d[B_RUN])   st_d.b.run   = wval[B_RUN];
        if (sel_d[B_PAUSE]) st_d.b.pause = wval[B_PAUSE];
        if (sel_d[B_WAKE])  st_d.b.wake  = wval[B_WAKE];

        if (eng_flush_done) st_d.b.flush = 1'b0;
        if (sel_d[B_FLUSH]) st_d.b.flush = wval[B_FLUSH];

        if (clr_d[B_DEAD]) st_d.b.dead = 1'b0;
        if (eng_dead)      st_d.b.dead = 1'b1;

        if (clr_d[B_BT]) st_d.b.bt = 1'b0;
        if (eng_bt)      st_d.b.bt = 1'b1;

        st_d.b.active = eng_active & ~clr_d[B_ACTIVE];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign bits = st_q.b;

    always_comb begin
        status_word           = '0;
        status_word[B_RUN]    = st_q.b.run;
        status_word[B_PAUSE]  = st_q.b.pause;
        status_word[B_FLUSH]  = st_q.b.flush;
        status_word[B_WAKE]   = st_q.b.wake;
        status_word[B_DEAD]   = st_q.b.dead;
        status_word[B_ACTIVE] = st_q.b.active;
        status_word[B_BT]     = st_q.b.bt;
        status_word[DEV_W-1:0] = st_q.dev;
    end

    p_sticky_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eng_dead |=> st_q.b.dead);

    p_no_sw_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && wmask[B_DEAD] && wval[B_DEAD] && !eng_dead && !st_q.b.dead) |=> !st_q.b.dead);

    p_flush_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (eng_flush_done && !(ctl_we && wmask[B_FLUSH])) |=> !st_q.b.flush);

    p_run_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && wmask[B_RUN] && !wval[B_RUN]) |=> !st_q.b.run);

    p_active_mirror_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(ctl_we && wmask[B_ACTIVE] && !wval[B_ACTIVE]) |=> (st_q.b.active == $past(eng_active)));
endmodule

// File: rtl/chan_cond_eval.sv
module chan_cond_eval
    import dma_chan_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [WORD_W-1:0] wdata,
    input  logic [HALF_W-1:0] status_lo,
    output logic [WORD_W-1:0] sel_word,
    output logic              hit
);
    typedef struct packed {
        logic [HALF_W-1:0] mask;
        logic [HALF_W-1:0] value;
    } sel_t;

    sel_t sel_d, sel_q;

    always_comb begin
        sel_d = sel_q;
        if (we) sel_d = sel_t'(wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    assign sel_word = sel_q;
    assign hit      = ((status_lo & sel_q.mask) == sel_q.value);

    p_sel_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (sel_word == $past(wdata)));
endmodule

// File: rtl/chan_ptr_regs.sv
module chan_ptr_regs
    import dma_chan_pkg::*;
#(
    parameter int unsigned ALIGN_BITS = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_hi,
    input  logic              we_lo,
    input  logic              we_mode,
    input  logic [WORD_W-1:0] wdata,
    input  logic              run,
    output logic [WORD_W-1:0] ptr_hi,
    output logic [WORD_W-1:0] ptr_lo,
    output logic [WORD_W-1:0] mode
);
    localparam logic [WORD_W-1:0] LO_KEEP = ~((WORD_W'(1) << ALIGN_BITS) - WORD_W'(1));

    typedef struct packed {
        logic [WORD_W-1:0] hi;
        logic [WORD_W-1:0] lo;
        logic [WORD_W-1:0] mode;
    } ptr_t;

    ptr_t pr_d, pr_q;

    always_comb begin
        pr_d = pr_q;
        if (we_hi && !run) pr_d.hi = wdata;
        if (we_lo && !run) pr_d.lo = wdata & LO_KEEP;
        if (we_mode)       pr_d.mode = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pr_q <= '0;
        else        pr_q <= pr_d;
    end

    assign ptr_hi = pr_q.hi;
    assign ptr_lo = pr_q.lo;
    assign mode   = pr_q.mode;

    p_ptr_locked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (we_hi || we_lo)) |=> $stable({ptr_hi, ptr_lo}));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
    import dma_chan_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [2:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        eng_active,
    input  logic        eng_dead,
    input  logic        eng_bt,
    input  logic        eng_flush_done,
    input  logic [7:0]  dev_status,
    output logic        ctl_run,
    output logic        ctl_pause,
    output logic        ctl_flush,
    output logic        ctl_wake,
    output logic [63:0] cmd_ptr,
    output logic [31:0] xfer_mode,
    output logic        cond_intr,
    output logic        cond_br,
    output logic        cond_wait
);
    reg_addr_e         addr_e;
    chan_bits_t        bits;
    logic [WORD_W-1:0] status_word;
    logic [WORD_W-1:0] ptr_hi, ptr_lo, mode;
    logic [WORD_W-1:0] sel_word [N_COND];
    logic [N_COND-1:0] sel_we;
    logic [N_COND-1:0] hit;

    assign addr_e = reg_addr_e'(bus_addr);

    chan_status_reg u_status (
        .clk            (clk),
        .rst_n          (rst_n),
        .ctl_we         (bus_wr && addr_e == A_CTRL),
        .wmask          (bus_wdata[WORD_W-1:HALF_W]),
        .wval           (bus_wdata[HALF_W-1:0]),
        .eng_active     (eng_active),
        .eng_dead       (eng_dead),
        .eng_bt         (eng_bt),
        .eng_flush_done (eng_flush_done),
        .dev_status     (dev_status),
        .bits           (bits),
        .status_word    (status_word)
    );

    chan_ptr_regs #(.ALIGN_BITS(4)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_hi   (bus_wr && addr_e == A_PTR_HI),
        .we_lo   (bus_wr && addr_e == A_PTR_LO),
        .we_mode (bus_wr && addr_e == A_XMODE),
        .wdata   (bus_wdata),
        .run     (bits.run),
        .ptr_hi  (ptr_hi),
        .ptr_lo  (ptr_lo),
        .mode    (mode)
    );

    for (genvar gi = 0; gi < N_COND; gi++) begin : g_cond
        localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(A_SEL_INT) + gi);
        assign sel_we[gi] = bus_wr && (bus_addr == MY_ADDR);
        chan_cond_eval u_cond (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (sel_we[gi]),
            .wdata     (bus_wdata),
            .status_lo (status_word[HALF_W-1:0]),
            .sel_word  (sel_word[gi]),
            .hit       (hit[gi])
        );
    end

    always_comb begin
        unique case (addr_e)
            A_CTRL, A_STAT: bus_rdata = status_word;
            A_PTR_HI:       bus_rdata = ptr_hi;
            A_PTR_LO:       bus_rdata = ptr_lo;
            A_SEL_INT:      bus_rdata = sel_word[0];
            A_SEL_BR:       bus_rdata = sel_word[1];
            A_SEL_WAIT:     bus_rdata = sel_word[2];
            A_XMODE:        bus_rdata = mode;
            default:        bus_rdata = '0;
        endcase
    end

    assign ctl_run   = bits.run;
    assign ctl_pause = bits.pause;
    assign ctl_flush = bits.flush;
    assign ctl_wake  = bits.wake;
    assign cmd_ptr   = {ptr_hi, ptr_lo};
    assign xfer_mode = mode;
    assign cond_intr = hit[0];
    assign cond_br   = hit[1];
    assign cond_wait = hit[2];

    p_ctl_mirror_r12: assert property (@(posedge clk) disable iff (!rst_n)
        {ctl_run, ctl_pause, ctl_flush, ctl_wake} == status_word[15:12]);
endmodule

// File: tb/test_dma_chan_regs.sv
module test_dma_chan_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        eng_active = 1'b0, eng_dead = 1'b0, eng_bt = 1'b0, eng_flush_done = 1'b0;
    logic [7:0]  dev_status = '0;
    logic        ctl_run, ctl_pause, ctl_flush, ctl_wake;
    logic [63:0] cmd_ptr;
    logic [31:0] xfer_mode;
    logic        cond_intr, cond_br, cond_wait;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    logic [3:0] e_ctl = '0;
    logic       e_dead = 0, e_act = 0, e_bt = 0;
    logic [7:0] e_dev = '0;
    logic [31:0] rv;

    always #10 clk = ~clk;

    dma_chan_regs i_dma_chan_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .eng_active(eng_active),
        .eng_dead(eng_dead), .eng_bt(eng_bt), .eng_flush_done(eng_flush_done),
        .dev_status(dev_status), .ctl_run(ctl_run), .ctl_pause(ctl_pause),
        .ctl_flush(ctl_flush), .ctl_wake(ctl_wake), .cmd_ptr(cmd_ptr),
        .xfer_mode(xfer_mode), .cond_intr(cond_intr), .cond_br(cond_br),
        .cond_wait(cond_wait)
    );

    function automatic logic [31:0] exp_stat();
        return {16'h0, e_ctl, e_dead, e_act, 1'b0, e_bt, e_dev};
    endfunction

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic chk_stat(input string req);
        rd(3'd1, rv);
        chk(req, {32'h0, rv}, {32'h0, exp_stat()});
        chk({req, "_R12"}, {60'h0, ctl_run, ctl_pause, ctl_flush, ctl_wake}, {60'h0, e_ctl});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R1 watchdog actual=hung expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset values
        chk_stat("R1");
        for (int a = 2; a < 8; a++) begin
            rd(3'(a), rv);
            chk("R1", {32'h0, rv}, 64'h0);
        end

        // R2: sweep every mask/value pair over the four control bits; low bits ignored
        for (int m = 0; m < 16; m++) begin
            for (int v = 0; v < 16; v++) begin
                wr(3'd0, {4'(m), 12'h000, 4'(v), 12'hFFF});
                e_ctl = (e_ctl & ~4'(m)) | (4'(v) & 4'(m));
                chk_stat("R2");
            end
        end

        // R4: software cannot set engine-owned or device bits
        wr(3'd0, 32'hFFFF_FFFF);
        e_ctl = 4'hF;
        chk_stat("R4");

        // R5: engine pulses set sticky bits
        eng_dead = 1; eng_bt = 1;
        @(negedge clk);
        eng_dead = 0; eng_bt = 0;
        e_dead = 1; e_bt = 1;
        chk_stat("R5");
        repeat (3) @(negedge clk);
        chk_stat("R5");
        // R4: software clear of DEAD
        wr(3'd0, 32'h0800_0000);
        e_dead = 0;
        chk_stat("R4");
        // R5: engine set wins over same-cycle software clear
        eng_bt = 1;
        wr(3'd0, 32'h0100_0000);
        eng_bt = 0;
        chk_stat("R5");
        wr(3'd0, 32'h0100_0000);
        e_bt = 0;
        chk_stat("R4");

        // R6: ACTIVE mirrors engine, software clear lasts one update
        eng_active = 1;
        @(negedge clk);
        e_act = 1;
        chk_stat("R6");
        wr(3'd0, 32'h0400_0000);
        e_act = 0;
        chk_stat("R6");
        @(negedge clk);
        e_act = 1;
        chk_stat("R6");
        eng_active = 0;
        @(negedge clk);
        e_act = 0;
        chk_stat("R6");

        // R7: flush done clears FLUSH; software write in the same cycle wins
        eng_flush_done = 1;
        @(negedge clk);
        eng_flush_done = 0;
        e_ctl[1] = 0;
        chk_stat("R7");
        eng_flush_done = 1;
        wr(3'd0, 32'h2000_2000);
        eng_flush_done = 0;
        e_ctl[1] = 1;
        chk_stat("R7");
        // stop request: mask RUN|FLUSH, values zero
        wr(3'd0, 32'hA000_0000);
        e_ctl[3] = 0; e_ctl[1] = 0;
        chk_stat("R7");

        // R3: reset request with everything set
        wr(3'd0, 32'hF000_F000);
        eng_dead = 1;
        @(negedge clk);
        eng_dead = 0;
        e_ctl = 4'hF; e_dead = 1;
        chk_stat("R3");
        wr(3'd0, 32'hFC00_0000);
        e_ctl = 4'h0; e_dead = 0;
        chk_stat("R3");
        chk("R3", {63'h0, ctl_run}, 64'h0);

        // R10 selects, then R8/R10 device status sweep
        wr(3'd4, 32'h00F0_0050);
        wr(3'd5, 32'h0003_0001);
        wr(3'd6, 32'h00FF_00A5);
        for (int d = 0; d < 256; d++) begin
            dev_status = 8'(d);
            @(negedge clk);
            e_dev = 8'(d);
            rd(3'd0, rv);
            chk("R8", {32'h0, rv}, {32'h0, exp_stat()});
            rd(3'd1, rv);
            chk("R8", {32'h0, rv}, {32'h0, exp_stat()});
            chk("R10", {63'h0, cond_intr}, {63'h0, (d & 8'hF0) == 8'h50});
            chk("R10", {63'h0, cond_br},   {63'h0, (d & 8'h03) == 8'h01});
            chk("R10", {63'h0, cond_wait}, {63'h0, d == 8'hA5});
        end
        dev_status = 0;
        @(negedge clk);
        e_dev = 0;

        // R9/R11: pointer loads while stopped, alignment, readback
        wr(3'd2, 32'hDEAD_BEEF);
        wr(3'd3, 32'h1234_567F);
        wr(3'd7, 32'hA5A5_0F0F);
        rd(3'd2, rv); chk("R9", {32'h0, rv}, 64'hDEAD_BEEF);
        rd(3'd3, rv); chk("R9", {32'h0, rv}, 64'h1234_5670);
        rd(3'd7, rv); chk("R11", {32'h0, rv}, 64'hA5A5_0F0F);
        rd(3'd4, rv); chk("R11", {32'h0, rv}, 64'h00F0_0050);
        rd(3'd6, rv); chk("R11", {32'h0, rv}, 64'h00FF_00A5);
        chk("R9", cmd_ptr, 64'hDEAD_BEEF_1234_5670);
        chk("R11", {32'h0, xfer_mode}, 64'hA5A5_0F0F);

        // R9: writes dropped while running; R11: mode and selects still writable
        wr(3'd0, 32'h8000_8000);
        e_ctl[3] = 1;
        wr(3'd2, 32'h1111_1111);
        wr(3'd3, 32'h2222_2222);
        wr(3'd7, 32'h0000_005A);
        wr(3'd5, 32'h1234_4321);
        rd(3'd2, rv); chk("R9", {32'h0, rv}, 64'hDEAD_BEEF);
        rd(3'd3, rv); chk("R9", {32'h0, rv}, 64'h1234_5670);
        chk("R9", cmd_ptr, 64'hDEAD_BEEF_1234_5670);
        rd(3'd7, rv); chk("R11", {32'h0, rv}, 64'h0000_005A);
        rd(3'd5, rv); chk("R11", {32'h0, rv}, 64'h1234_4321);
        chk_stat("R2");

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule